// File: doc/BRIEF.md
# Two-Level Address Translation Walker with Large Pages

This block turns a 32-bit linear address into a 32-bit physical address by reading page-structure entries from memory. A request is taken on a valid/ready channel. The walker first reads one entry from a 1024-entry directory. The directory's 4KB-aligned frame is supplied on an input. Depending on that entry and a global large-page enable, the walker either stops there with a 4MB page or reads a second entry from a page table and forms a 4KB page address. The result is either a physical address or a not-present fault. A fault also reports whether the directory level or the table level was missing.

Memory is read one 32-bit word at a time. Each read request uses valid/ready. The read request holds its address until the memory side accepts it. No further read is issued until a response strobe arrives, and the wait for that strobe has no limit. The request channel applies back-pressure by dropping `req_ready` for the whole walk. The result is a one-cycle pulse with no ready signal, so the consumer must take it when it appears. The large-page enable and the directory frame are plain control inputs. The block keeps no translations, so changing the enable affects only walks that read a directory entry later.

Top module: `xw_walker`

## Requirements
- R1: The directory entry is read from the word address {dir_frame[19:0], lin[31:22], 2'b00}.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high, and `req_ready` is high only when no walk is in progress. Each accepted request produces exactly one `res_valid` pulse, one cycle long. That pulse appears in the cycle after the last memory response, and `req_ready` returns in the cycle after the pulse. Requests offered during a walk are not taken.
- R3: With `large_en` = 0, every present directory entry leads to a table read, whatever the value of entry bit 7.
- R4: With `large_en` = 1 and directory entry bit 7 = 0, the walk still reads the page table.
- R5: With `large_en` = 1 and directory entry bit 7 = 1, no table read is made. The result is {pde[31:22], lin[21:0]}, so directory entry bits 21:12 have no effect and the page is 4MB aligned.
- R6: The table entry is read from {pde[31:12], lin[21:12], 2'b00}. A present table entry gives the result {pte[31:12], lin[11:0]}.
- R7: Bit 0 of an entry is its present bit. If the directory entry has bit 0 = 0, the walk ends with `res_fault` = 1 and `res_fault_tbl` = 0, and no table read is made. If the table entry has bit 0 = 0, the walk ends with `res_fault` = 1 and `res_fault_tbl` = 1. A successful walk has `res_fault` = 0.
- R8: `large_en` is used only when a directory entry arrives. Toggling it between walks leaves no trace, so the same address can give a 4MB result and then a 4KB result on later walks.
- R9: Only one memory read is outstanding at a time. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. It then stays low until `mem_rsp_valid` arrives, however many cycles that takes.
- R10: After reset, `req_ready` = 1, and `mem_req_valid` and `res_valid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| large_en | input | 1 | Global enable for 4MB pages |
| dir_frame | input | 20 | Directory base frame (physical address bits 31:12) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Physical address (meaningful when no fault) |
| res_fault | output | 1 | Walk ended on a not-present entry |
| res_fault_tbl | output | 1 | Fault level: 1 = table, 0 = directory |

## Verification
The same linear address is walked with the enable low and then high while its directory entry has bit 7 set. This distinguishes a one-read 4MB result from a two-read 4KB result, and the directory entry carries non-zero bits 21:12 to show they are dropped. A second address whose entry has bit 7 clear is walked under both enable values to confirm that the enable alone never shortens a walk. Entries with a clear present bit at each level, an address indexing the last directory slot, and a random mix of addresses and enable values with random memory stalls and response delays check fault reporting, the one-outstanding rule and the refusal of requests during a walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_RD_DIR  = 2'd1,
    WS_RD_TBL  = 2'd2,
    WS_DONE    = 2'd3
  } walk_st_e;
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFS_W     = 12
) (
  input  logic                                   sel_tbl,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]         dir_frame,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]         tbl_frame,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:OFS_W] lin_hi,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0]   addr
);
  localparam int ADDR_W  = DIR_IDX_W + TBL_IDX_W + OFS_W;
  localparam int BIG_W   = TBL_IDX_W + OFS_W;
  localparam int PAD_W   = OFS_W - DIR_IDX_W;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;

  assign dir_addr = {dir_frame, lin_hi[ADDR_W-1:BIG_W], {PAD_W{1'b0}}};
  assign tbl_addr = {tbl_frame, lin_hi[BIG_W-1:OFS_W], {PAD_W{1'b0}}};
  assign addr     = sel_tbl ? tbl_addr : dir_addr;
endmodule

// File: rtl/xw_pa_compose.sv
module xw_pa_compose #(
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFS_W     = 12
) (
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] lin,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]       entry_frame,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] pa_big,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] pa_small
);
  localparam int FRAME_W = DIR_IDX_W + TBL_IDX_W;
  localparam int BIG_W   = TBL_IDX_W + OFS_W;

  assign pa_big   = {entry_frame[FRAME_W-1:TBL_IDX_W], lin[BIG_W-1:0]};
  assign pa_small = {entry_frame, lin[OFS_W-1:0]};
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
  import xw_pkg::*;
#(
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int OFS_W       = 12,
  parameter int PS_BIT      = 7,
  parameter int PRESENT_BIT = 0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 large_en,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] req_lin,
  output logic                                 mem_req_valid,
  input  logic                                 mem_req_ready,
  input  logic                                 mem_rsp_valid,
  input  logic                                 rsp_present,
  input  logic                                 rsp_ps,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]       rsp_frame,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] pa_big,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] pa_small,
  output logic                                 sel_tbl,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] lin_q,
  output logic [DIR_IDX_W+TBL_IDX_W-1:0]       tbl_frame_q,
  output logic                                 res_valid,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] res_paddr,
  output logic                                 res_fault,
  output logic                                 res_fault_tbl
);
  localparam int ADDR_W  = DIR_IDX_W + TBL_IDX_W + OFS_W;
  localparam int FRAME_W = DIR_IDX_W + TBL_IDX_W;

  walk_st_e          st_q;
  logic              issued_q;
  logic              rsp_take;
  logic              go_big;
  logic [ADDR_W-1:0] pa_q;
  logic              flt_q;
  logic              flt_tbl_q;

  assign req_ready     = (st_q == WS_IDLE);
  assign sel_tbl       = (st_q == WS_RD_TBL);
  assign mem_req_valid = ((st_q == WS_RD_DIR) || (st_q == WS_RD_TBL)) && !issued_q;
  assign rsp_take      = issued_q && mem_rsp_valid &&
                         ((st_q == WS_RD_DIR) || (st_q == WS_RD_TBL));
  assign go_big        = large_en && rsp_ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= WS_IDLE;
      issued_q    <= 1'b0;
      lin_q       <= '0;
      tbl_frame_q <= '0;
      pa_q        <= '0;
      flt_q       <= 1'b0;
      flt_tbl_q   <= 1'b0;
    end else begin
      case (st_q)
        WS_IDLE: begin
          if (req_valid) begin
            lin_q     <= req_lin;
            issued_q  <= 1'b0;
            flt_q     <= 1'b0;
            flt_tbl_q <= 1'b0;
            st_q      <= WS_RD_DIR;
          end
        end
        WS_RD_DIR: begin
          if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
          if (rsp_take) begin
            if (!rsp_present) begin
              flt_q     <= 1'b1;
              flt_tbl_q <= 1'b0;
              pa_q      <= '0;
              st_q      <= WS_DONE;
            end else if (go_big) begin
              pa_q <= pa_big;
              st_q <= WS_DONE;
            end else begin
              tbl_frame_q <= rsp_frame;
              issued_q    <= 1'b0;
              st_q        <= WS_RD_TBL;
            end
          end
        end
        WS_RD_TBL: begin
          if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
          if (rsp_take) begin
            if (!rsp_present) begin
              flt_q     <= 1'b1;
              flt_tbl_q <= 1'b1;
              pa_q      <= '0;
            end else begin
              pa_q <= pa_small;
            end
            st_q <= WS_DONE;
          end
        end
        default: begin
          issued_q <= 1'b0;
          st_q     <= WS_IDLE;
        end
      endcase
    end
  end

  assign res_valid     = (st_q == WS_DONE);
  assign res_paddr     = pa_q;
  assign res_fault     = flt_q;
  assign res_fault_tbl = flt_tbl_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid) else $error("read request dropped"); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid) else $error("second read issued"); // R9
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && req_ready) else $error("result not a single pulse"); // R2
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready) else $error("ready during walk"); // R2
  AST_READ_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !res_valid) else $error("read outside walk"); // R9

  logic unused_frame_lo;
  assign unused_frame_lo = ^rsp_frame[FRAME_W-1:0] & 1'b0;
endmodule

// File: rtl/xw_walker.sv
module xw_walker #(
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int OFS_W       = 12,
  parameter int PS_BIT      = 7,
  parameter int PRESENT_BIT = 0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 large_en,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]       dir_frame,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] req_lin,
  output logic                                 mem_req_valid,
  input  logic                                 mem_req_ready,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] mem_req_addr,
  input  logic                                 mem_rsp_valid,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] mem_rsp_data,
  output logic                                 res_valid,
  output logic [DIR_IDX_W+TBL_IDX_W+OFS_W-1:0] res_paddr,
  output logic                                 res_fault,
  output logic                                 res_fault_tbl
);
  localparam int ADDR_W  = DIR_IDX_W + TBL_IDX_W + OFS_W;
  localparam int FRAME_W = DIR_IDX_W + TBL_IDX_W;

  logic               sel_tbl;
  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [ADDR_W-1:0]  pa_big;
  logic [ADDR_W-1:0]  pa_small;
  logic [FRAME_W-1:0] rsp_frame;
  logic               unused_rsp_bits;

  assign rsp_frame       = mem_rsp_data[ADDR_W-1:OFS_W];
  assign unused_rsp_bits = ^mem_rsp_data[OFS_W-1:0];

  xw_addr_gen #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFS_W(OFS_W)) u_addr (
    .sel_tbl   (sel_tbl),
    .dir_frame (dir_frame),
    .tbl_frame (tbl_frame_q),
    .lin_hi    (lin_q[ADDR_W-1:OFS_W]),
    .addr      (mem_req_addr)
  );

  xw_pa_compose #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFS_W(OFS_W)) u_pa (
    .lin         (lin_q),
    .entry_frame (rsp_frame),
    .pa_big      (pa_big),
    .pa_small    (pa_small)
  );

  xw_walk_fsm #(
    .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFS_W(OFS_W),
    .PS_BIT(PS_BIT), .PRESENT_BIT(PRESENT_BIT)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .large_en      (large_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_present   (mem_rsp_data[PRESENT_BIT]),
    .rsp_ps        (mem_rsp_data[PS_BIT]),
    .rsp_frame     (rsp_frame),
    .pa_big        (pa_big),
    .pa_small      (pa_small),
    .sel_tbl       (sel_tbl),
    .lin_q         (lin_q),
    .tbl_frame_q   (tbl_frame_q),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault),
    .res_fault_tbl (res_fault_tbl)
  );

  AST_STABLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)) else $error("read address moved"); // R9
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault_tbl |-> res_fault) else $error("table level without fault"); // R7
endmodule

// File: tb/sim_xw_walker.sv
module sim_xw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        large_en = 1'b0;
  logic [19:0] dir_frame = 20'h00100;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_fault_tbl;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  xw_walker u0 (
    .clk(clk), .rst_n(rst_n), .large_en(large_en), .dir_frame(dir_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_fault_tbl(res_fault_tbl)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: addresses read and final outcome
  task automatic ref_walk(input logic [31:0] lin, input bit lg,
                          output logic [31:0] a0, output logic [31:0] a1, output int nrd,
                          output logic [31:0] pa, output bit flt, output bit ftbl);
    logic [31:0] pde, pte;
    a0 = {dir_frame, lin[31:22], 2'b00};
    a1 = '0; pa = '0; flt = 0; ftbl = 0;
    pde = rd(a0);
    nrd = 1;
    if (pde[0] == 1'b0) begin
      flt = 1;
    end else if (lg && pde[7]) begin
      pa = {pde[31:22], lin[21:0]};
    end else begin
      a1 = {pde[31:12], lin[21:12], 2'b00};
      nrd = 2;
      pte = rd(a1);
      if (pte[0] == 1'b0) begin flt = 1; ftbl = 1; end
      else pa = {pte[31:12], lin[11:0]};
    end
  endtask

  task automatic do_xlat(input logic [31:0] lin, input bit lg, input string tag);
    logic [31:0] a0, a1, epa, ea;
    int nrd;
    bit ef, et;
    ref_walk(lin, lg, a0, a1, nrd, epa, ef, et);
    @(negedge clk);
    large_en = lg;
    chk(req_ready === 1'b1, "R2", "idle ready", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_lin = lin;
    @(negedge clk);
    req_valid = 1'b0;
    for (int r = 0; r < nrd; r++) begin
      int st = $urandom_range(0, 3);
      int lat = $urandom_range(1, 4);
      ea = (r == 0) ? a0 : a1;
      mem_req_ready = 1'b0;
      for (int s = 0; s < st; s++) begin
        chk(mem_req_valid === 1'b1, "R9", "held request", {31'b0, mem_req_valid}, 32'd1);
        chk(mem_req_addr === ea, (r == 0) ? "R1" : "R6", "stalled addr", mem_req_addr, ea);
        chk(req_ready === 1'b0, "R2", "busy ready", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
      end
      chk(mem_req_valid === 1'b1, "R9", "request valid", {31'b0, mem_req_valid}, 32'd1);
      chk(mem_req_addr === ea, (r == 0) ? "R1" : "R6", "read addr", mem_req_addr, ea);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int w = 0; w < lat; w++) begin
        chk(mem_req_valid === 1'b0, "R9", "one outstanding", {31'b0, mem_req_valid}, 32'd0);
        chk(res_valid === 1'b0, "R2", "early result", {31'b0, res_valid}, 32'd0);
        req_valid = 1'b1; req_lin = ~lin;   // must be refused (R2)
        @(negedge clk);
      end
      req_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = rd(ea);
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end
    chk(res_valid === 1'b1, "R2", {tag, " result pulse"}, {31'b0, res_valid}, 32'd1);
    chk(mem_req_valid === 1'b0, (nrd == 1) ? "R5" : "R6", {tag, " no extra read"},
        {31'b0, mem_req_valid}, 32'd0);
    chk(res_fault === ef, "R7", {tag, " fault"}, {31'b0, res_fault}, {31'b0, ef});
    if (ef)
      chk(res_fault_tbl === et, "R7", {tag, " fault level"}, {31'b0, res_fault_tbl}, {31'b0, et});
    else
      chk(res_paddr === epa, tag, "paddr", res_paddr, epa);
    @(negedge clk);
    chk(res_valid === 1'b0, "R2", "pulse length", {31'b0, res_valid}, 32'd0);
    chk(req_ready === 1'b1, "R2", "ready after result", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // directory at 0x00100000
    mem[32'h0010000C] = 32'h0A2F3081;  // idx 3: present, size bit set, bits 21:12 nonzero
    for (int i = 0; i < 1024; i++)
      mem[32'h0A2F3000 + 32'(i * 4)] = {12'h123, 10'(i), 10'h001};
    mem[32'h00100014] = 32'h33C45001;  // idx 5: present, size bit clear
    mem[32'h33C45008] = 32'h7777F001;
    mem[32'h00100020] = 32'h00000080;  // idx 8: not present, size bit set
    mem[32'h00100024] = 32'h44400001;  // idx 9: present, table
    mem[32'h4440000C] = 32'h99999000;  // not present table entry
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "reset ready", {31'b0, req_ready}, 32'd1);
    chk(mem_req_valid === 1'b0, "R10", "reset read", {31'b0, mem_req_valid}, 32'd0);
    chk(res_valid === 1'b0, "R10", "reset result", {31'b0, res_valid}, 32'd0);

    do_xlat(32'h00C01234, 1'b0, "R3");
    do_xlat(32'h00C01234, 1'b1, "R5");
    do_xlat(32'h00C01234, 1'b0, "R8");
    do_xlat(32'h00FFFFFF, 1'b1, "R8");
    do_xlat(32'h01402ABC, 1'b1, "R4");
    do_xlat(32'h01402ABC, 1'b0, "R3");
    do_xlat(32'h02000000, 1'b1, "R7");
    do_xlat(32'h02000000, 1'b0, "R7");
    do_xlat(32'h02403000, 1'b1, "R7");
    do_xlat(32'hFFC00FFF, 1'b1, "R1");
    for (int k = 0; k < 60; k++) begin
      logic [31:0] l;
      int pick = $urandom_range(0, 3);
      l = $urandom;
      case (pick)
        0: l[31:22] = 10'd3;
        1: l[31:22] = 10'd5;
        2: l[31:22] = 10'd9;
        default: l[31:22] = 10'd8;
      endcase
      do_xlat(l, 1'($urandom_range(0, 1)), "R6");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule